// File: doc/BRIEF.md
# Hot-Swap Turn-On and Fault Sequencer

This block is the digital supervisor for a pass switch in a hot-plugged supply path. Analog comparators supply flags for supply undervoltage, current-loop limiting, a second and higher overcurrent trip, a short circuit, die over-temperature, die cool-down and gate fully on. The sequencer debounces the supply flag with a power-on-reset delay. It then turns the pass element on with the lower current limit selected. On the way it times overloads, reacts to faults and drives an active-low power-good output.

Every timer counts pulses of a slow tick input, nominally 1 kHz. The delays are parameters given in ticks: power-on delay, overcurrent timeout and restart delay. After any fault the switch stays off for the restart delay, and then the whole turn-on sequence runs again. Retries never stop. A thermal trip holds the switch off until the cool flag has been seen. All flag inputs pass through two flip-flops before the block uses them. The tick input is a clock enable from the same clock domain.

Top module: `hotswap_seq`

## Requirements
- R1: After reset all outputs are inactive: pass_en=0, lim_low=0, pwm_en=0, pgood_n=1.
- R2: While the supply flag is good, the pass element is enabled only after POR_TICKS ticks. Any drop of the supply flag during this delay restarts the count from zero.
- R3: When the power-on delay ends, pass_en turns on together with lim_low=1, which selects the lower inrush limit level.
- R4: Leaving the inrush phase needs the limiting flag clear and the gate-full flag set. Power-good (pgood_n=0) is shown only in that fully-on phase, and there lim_low=0.
- R5: In the inrush phase, limiting that lasts OC_TICKS ticks turns pass_en off and declares a fault. If limiting clears before the timeout, the count goes back to zero.
- R6: In the fully-on phase, a high-threshold trip returns the block to the inrush phase: lim_low=1, pgood_n=1, and overcurrent timing restarts.
- R7: After a fault the pass element stays off for RESTART_TICKS ticks. The power-on sequence then restarts by itself, and this repeats without limit.
- R8: pwm_en follows the short-circuit flag only while the pass element is on after the power-on delay. At all other times it is 0.
- R9: Loss of the supply flag in any state turns the pass element off at once and returns to idle. It does not wait for the restart delay.
- R10: An over-temperature flag turns the pass element off and holds it off. The hold lasts through any number of ticks until the cool flag is seen, even after the over-temperature flag itself has cleared.
- R11: Once the cool flag releases the thermal hold, the restart delay runs and turn-on follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle timebase pulse (nominally 1 kHz) |
| uv_ok | input | 1 | Supply above undervoltage threshold |
| limiting | input | 1 | Current loop is actively limiting |
| trip_hi | input | 1 | Higher overcurrent threshold tripped |
| short_det | input | 1 | Short-circuit condition detected |
| over_temp | input | 1 | Die over-temperature |
| cool_ok | input | 1 | Die cooled below release temperature |
| gate_full | input | 1 | Pass gate fully enhanced |
| pass_en | output | 1 | Pass element enable |
| lim_low | output | 1 | 1 selects the lower inrush current limit |
| pwm_en | output | 1 | Pulsed current-limit mode enable |
| pgood_n | output | 1 | Power good, active low |

## Verification
The assertions check, on every cycle, the relations between outputs and synchronized flags. Power-good never appears without the pass element on, and pulsed limiting never appears with the switch off. A lost supply or a hot die turns the switch off on the next cycle. An expired overcurrent timer does the same, a trip in the on phase restores the low limit, and every turn-on edge comes with the low limit. Only the bench scenarios can show the tick-counted durations: a bounce restarting the power-on count, limiting that clears and resets the overcurrent count, the retry loop closing, and the thermal hold lasting until the cool flag arrives.

// File: rtl/hsw_pkg.sv
package hsw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE         = 3'd0,
    ST_POR          = 3'd1,
    ST_INRUSH       = 3'd2,
    ST_ON           = 3'd3,
    ST_FAULT_WAIT   = 3'd4,
    ST_THERMAL_HOLD = 3'd5
  } hsw_state_e;

  localparam int FLAG_W    = 7;
  localparam int F_UV      = 0;
  localparam int F_LIMIT   = 1;
  localparam int F_TRIP    = 2;
  localparam int F_SHORT   = 3;
  localparam int F_HOT     = 4;
  localparam int F_COOL    = 5;
  localparam int F_GATE    = 6;
endpackage

// File: rtl/hsw_sync.sv
module hsw_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= '0;
        else if (i == 0) stg[i] <= d;
        else stg[i] <= stg[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hsw_tick_timer.sv
module hsw_tick_timer #(
  parameter int LIMIT = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  input  logic tick,
  output logic done
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (run && tick && (cnt != LIM)) cnt <= cnt + 1'b1;
  end

  assign done = (cnt == LIM);
endmodule

// File: rtl/hsw_thermal_latch.sv
module hsw_thermal_latch (
  input  logic clk,
  input  logic rst,
  input  logic hot_flag,
  input  logic cool_flag,
  output logic hot
);
  always_ff @(posedge clk) begin
    if (rst) hot <= 1'b0;
    else if (hot_flag) hot <= 1'b1;
    else if (cool_flag) hot <= 1'b0;
  end
endmodule

// File: rtl/hotswap_seq.sv
module hotswap_seq
  import hsw_pkg::*;
#(
  parameter int POR_TICKS     = 5,
  parameter int OC_TICKS      = 75,
  parameter int RESTART_TICKS = 9000
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic uv_ok,
  input  logic limiting,
  input  logic trip_hi,
  input  logic short_det,
  input  logic over_temp,
  input  logic cool_ok,
  input  logic gate_full,
  output logic pass_en,
  output logic lim_low,
  output logic pwm_en,
  output logic pgood_n
);
  logic [FLAG_W-1:0] raw_flags, s_flags;
  logic s_uv, s_lim, s_trip, s_short, s_gate;
  logic hot;
  logic por_done, oc_done, rs_done;
  hsw_state_e state_q, state_d;

  assign raw_flags[F_UV]    = uv_ok;
  assign raw_flags[F_LIMIT] = limiting;
  assign raw_flags[F_TRIP]  = trip_hi;
  assign raw_flags[F_SHORT] = short_det;
  assign raw_flags[F_HOT]   = over_temp;
  assign raw_flags[F_COOL]  = cool_ok;
  assign raw_flags[F_GATE]  = gate_full;

  hsw_sync #(.W(FLAG_W), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .d(raw_flags), .q(s_flags)
  );

  assign s_uv    = s_flags[F_UV];
  assign s_lim   = s_flags[F_LIMIT];
  assign s_trip  = s_flags[F_TRIP];
  assign s_short = s_flags[F_SHORT];
  assign s_gate  = s_flags[F_GATE];

  hsw_thermal_latch u_therm (
    .clk(clk), .rst(rst),
    .hot_flag(s_flags[F_HOT]), .cool_flag(s_flags[F_COOL]),
    .hot(hot)
  );

  hsw_tick_timer #(.LIMIT(POR_TICKS)) u_por_tmr (
    .clk(clk), .rst(rst), .tick(tick),
    .clr(state_q != ST_POR), .run(state_q == ST_POR),
    .done(por_done)
  );

  hsw_tick_timer #(.LIMIT(OC_TICKS)) u_oc_tmr (
    .clk(clk), .rst(rst), .tick(tick),
    .clr(!(state_q == ST_INRUSH && s_lim)),
    .run(state_q == ST_INRUSH && s_lim),
    .done(oc_done)
  );

  hsw_tick_timer #(.LIMIT(RESTART_TICKS)) u_rs_tmr (
    .clk(clk), .rst(rst), .tick(tick),
    .clr(state_q != ST_FAULT_WAIT), .run(state_q == ST_FAULT_WAIT),
    .done(rs_done)
  );

  always_comb begin
    state_d = state_q;
    if (hot) begin
      state_d = ST_THERMAL_HOLD;
    end else if (state_q == ST_THERMAL_HOLD) begin
      state_d = ST_FAULT_WAIT;
    end else if (!s_uv) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:       state_d = ST_POR;
        ST_POR:        if (por_done) state_d = ST_INRUSH;
        ST_INRUSH: begin
          if (oc_done) state_d = ST_FAULT_WAIT;
          else if (!s_lim && s_gate) state_d = ST_ON;
        end
        ST_ON:         if (s_trip) state_d = ST_INRUSH;
        ST_FAULT_WAIT: if (rs_done) state_d = ST_IDLE;
        default:       state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      pass_en <= 1'b0;
      lim_low <= 1'b0;
      pwm_en  <= 1'b0;
      pgood_n <= 1'b1;
    end else begin
      state_q <= state_d;
      pass_en <= (state_d == ST_INRUSH) || (state_d == ST_ON);
      lim_low <= (state_d == ST_INRUSH);
      pwm_en  <= ((state_d == ST_INRUSH) || (state_d == ST_ON)) && s_short;
      pgood_n <= !((state_d == ST_ON) && s_gate);
    end
  end
endmodule

// File: rtl/hsw_checker.sv
module hsw_checker
  import hsw_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input hsw_state_e state_q,
  input logic       s_uv,
  input logic       s_trip,
  input logic       hot,
  input logic       oc_done,
  input logic       pass_en,
  input logic       lim_low,
  input logic       pwm_en,
  input logic       pgood_n
);
  AST_PGOOD_NEEDS_PASS: assert property (@(posedge clk) disable iff (rst)
    !pgood_n |-> (pass_en && !lim_low)); // R4
  AST_PWM_NEEDS_PASS: assert property (@(posedge clk) disable iff (rst)
    pwm_en |-> pass_en); // R8
  AST_UV_LOSS_OFF: assert property (@(posedge clk) disable iff (rst)
    !s_uv |=> !pass_en); // R9
  AST_HOT_OFF: assert property (@(posedge clk) disable iff (rst)
    hot |=> (!pass_en && pgood_n)); // R10
  AST_OC_TIMEOUT_OFF: assert property (@(posedge clk) disable iff (rst)
    (oc_done && state_q == ST_INRUSH) |=> !pass_en); // R5
  AST_TRIP_LOW_LIMIT: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ON && s_trip && s_uv && !hot) |=> (lim_low && pgood_n)); // R6
  AST_TURN_ON_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(pass_en) |-> lim_low); // R3
endmodule

bind hotswap_seq hsw_checker u_chk (
  .clk(clk), .rst(rst), .state_q(state_q), .s_uv(s_uv), .s_trip(s_trip),
  .hot(hot), .oc_done(oc_done), .pass_en(pass_en), .lim_low(lim_low),
  .pwm_en(pwm_en), .pgood_n(pgood_n)
);

// File: tb/tb_hotswap_seq.sv
module tb_hotswap_seq;
  localparam int POR_T = 3;
  localparam int OC_T  = 4;
  localparam int RS_T  = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 0, uv_ok = 0, limiting = 0, trip_hi = 0, short_det = 0;
  logic over_temp = 0, cool_ok = 0, gate_full = 0;
  logic pass_en, lim_low, pwm_en, pgood_n;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  typedef struct {
    string      req;
    logic [3:0] exp;
  } item_t;
  item_t sb_q[$];

  always #4 clk = ~clk;

  hotswap_seq #(.POR_TICKS(POR_T), .OC_TICKS(OC_T), .RESTART_TICKS(RS_T)) dut (
    .clk(clk), .rst(rst), .tick(tick), .uv_ok(uv_ok), .limiting(limiting),
    .trip_hi(trip_hi), .short_det(short_det), .over_temp(over_temp),
    .cool_ok(cool_ok), .gate_full(gate_full), .pass_en(pass_en),
    .lim_low(lim_low), .pwm_en(pwm_en), .pgood_n(pgood_n)
  );

  // monitor: compares {pass_en, lim_low, pwm_en, pgood_n}
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      logic [3:0] act;
      it = sb_q.pop_front();
      act = {pass_en, lim_low, pwm_en, pgood_n};
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s actual=%b expected=%b", it.req, act, it.exp);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=200000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      settle(1);
      tick = 1'b0;
      settle(1);
    end
  endtask

  task automatic expect_out(input string req, input logic [3:0] exp);
    item_t it;
    it.req = req;
    it.exp = exp;
    sb_q.push_back(it);
    @(negedge clk);
    #1;
  endtask

  initial begin
    settle(3);
    rst = 1'b0;
    settle(1);
    expect_out("R1 reset outputs", 4'b0001);

    // power-on delay with a bounce
    uv_ok = 1; settle(4);
    pulse(POR_T - 1);
    expect_out("R2 still waiting before last tick", 4'b0001);
    uv_ok = 0; settle(4);
    uv_ok = 1; settle(4);
    pulse(POR_T - 1);
    expect_out("R2 bounce restarted count", 4'b0001);
    pulse(1); settle(3);
    expect_out("R3 on with low limit", 4'b1101);

    // fully on
    gate_full = 1; settle(4);
    expect_out("R4 power good in on phase", 4'b1000);

    // high trip back to inrush
    limiting = 1; trip_hi = 1; settle(4);
    expect_out("R6 trip returns to low limit", 4'b1101);
    trip_hi = 0; gate_full = 0; settle(4);

    // overcurrent timer reset then expiry
    pulse(OC_T - 1);
    limiting = 0; settle(4);
    limiting = 1; settle(4);
    pulse(OC_T - 1);
    expect_out("R5 count cleared when limiting stopped", 4'b1101);
    pulse(1); settle(3);
    expect_out("R5 timeout turns off", 4'b0001);

    // restart loop, short flag ignored while off
    limiting = 0; short_det = 1; settle(4);
    expect_out("R8 no pulsed mode while off", 4'b0001);
    pulse(RS_T - 1);
    expect_out("R7 still off before restart delay ends", 4'b0001);
    pulse(1); settle(3);
    pulse(POR_T); settle(3);
    expect_out("R7 R8 retry turned on with pulsed mode", 4'b1111);

    // supply loss
    uv_ok = 0; settle(4);
    expect_out("R9 supply loss turns off", 4'b0001);

    // thermal hold
    short_det = 0; uv_ok = 1; settle(4);
    pulse(POR_T); settle(3);
    gate_full = 1; settle(4);
    expect_out("R4 on again before thermal", 4'b1000);
    over_temp = 1; settle(4);
    expect_out("R10 over-temp turns off", 4'b0001);
    over_temp = 0; settle(4);
    pulse(RS_T + POR_T + 2); settle(3);
    expect_out("R10 held off until cool", 4'b0001);
    cool_ok = 1; settle(4);
    cool_ok = 0;
    pulse(RS_T); settle(3);
    pulse(POR_T); settle(3);
    expect_out("R11 cool releases, restart then on", 4'b1000);

    settle(2);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule